// File: doc/BRIEF.md
# Message Object Table Scanner

This block looks up a received CAN identifier in a table of message objects held in a byte-wide message RAM. It shares that RAM with a CPU. Software lays the objects out back to back from address 0, 16 bytes per slot. It can close the table early by writing a terminator byte into the first byte of the slot after the last object. When a start request arrives with an identifier, the scanner reads the slots in order and stops at the first object that accepts the frame. It also stops at the terminator or at the end of the RAM.

The result is written to an 8-bit index register, together with a one-cycle done pulse:
- Codes 0 to 253 give the number of the accepting object.
- 255 means that no object accepted the frame.
- 254 means that the frame finished before the scan did.

The CPU port always takes priority. While the CPU is accessing the RAM, the scanner waits and keeps its place. A frame-end input acts as the scan deadline. If it arrives while a scan is running, the scan is abandoned and a sticky overrun flag is set.

Top module: `msgscan_top`

## Requirements
- R1: Object k occupies bytes k*16 to k*16+15. Byte 0 of a slot is its mode byte: bit 0 = enabled, bit 1 = accept-all, bit 2 = transmit object. Bytes 1 and 2 hold the 11-bit identifier: byte 1 = id[10:3] and byte 2 bits 7:5 = id[2:0].
- R2: A mode byte of 8'hFF ends the table. The scan reports 255, and no slot after the terminator can produce a match.
- R3: With no terminator, the scan stops after the last slot (32 slots for 512 bytes) and reports 255 if nothing matched.
- R4: The lowest-numbered accepting object wins, and its number is reported. A later object with the same identifier is never reported.
- R5: An enabled, non-transmit, accept-all object matches any identifier. A disabled object or a transmit object never matches, even when its stored identifier is equal.
- R6: A CPU request is served in the same cycle; read data appears on cpu_rdata one cycle later. Each cycle in which the CPU holds the port while the scanner wants to issue a read delays the result by exactly one cycle and leaves it unchanged.
- R7: Timing with no CPU traffic: each byte read costs 2 cycles. A slot rejected on its mode byte costs 2 cycles, a slot that needs an identifier compare costs 6 cycles, and the done pulse follows the last read of the deciding slot.
- R8: A frame_end pulse while a scan is running stops the scan on that edge and reports 254 with done. It also sets overrun, which stays set until reset. A frame_end pulse while idle has no effect.
- R9: done is high for exactly one cycle for each scan. busy is high from the cycle after an accepted start until done. A start request while busy is ignored.
- R10: After reset the index reads 255, and done, busy and overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a scan with rx_id_i |
| rx_id_i | input | 11 | Received identifier |
| frame_end_i | input | 1 | Deadline: the minimum frame has ended |
| cpu_req_i | input | 1 | CPU RAM access request |
| cpu_we_i | input | 1 | CPU write enable |
| cpu_addr_i | input | 9 | CPU byte address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, one cycle after the request |
| idx_o | output | 8 | Result index register |
| done_o | output | 1 | One-cycle pulse when idx_o is updated |
| busy_o | output | 1 | Scan in progress |
| overrun_o | output | 1 | Sticky deadline-overrun flag |

## Verification
The table is first filled with 32 enabled objects that all have different identifiers. The bench searches for every one of them and for an identifier that is absent. This separates the hit position from the miss path, and the measured latency confirms the 6-cycle compare cost per slot.

A terminator is then moved through every slot, with an accept-all object placed just after it. This shows that the scan really stops at the terminator and does not simply miss.

Further patterns cover:
- duplicate identifiers;
- disabled and transmit objects that hold the wanted identifier, ahead of an accept-all object;
- CPU bursts, an early frame_end and a start request that arrives mid-scan.

These separate priority and stall effects from the lookup itself.

// File: rtl/msgscan_pkg.sv
package msgscan_pkg;
    localparam int          ID_W       = 11;
    localparam logic [7:0]  IDX_EMPTY  = 8'hFF;
    localparam logic [7:0]  IDX_ERROR  = 8'hFE;
    localparam logic [7:0]  END_MARK   = 8'hFF;
    localparam int          MODE_EN    = 0;
    localparam int          MODE_ALL   = 1;
    localparam int          MODE_TX    = 2;
    localparam int          MAX_OBJS   = 254;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } walk_state_e;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_ID_HI = 2'd1,
        SEL_ID_LO = 2'd2
    } byte_sel_e;
endpackage

// File: rtl/msgscan_ram.sv
module msgscan_ram #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en_i && we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
        if (en_i && !we_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/msgscan_arb.sv
module msgscan_arb #(
    parameter int ADDR_W = 9
) (
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [7:0]        cpu_wdata_i,
    input  logic              scan_req_i,
    input  logic [ADDR_W-1:0] scan_addr_i,
    output logic              scan_gnt_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o
);
    // The CPU owns the port whenever it asks; the scanner only gets idle cycles.
    always_comb begin
        scan_gnt_o  = scan_req_i && !cpu_req_i;
        mem_en_o    = cpu_req_i || scan_req_i;
        mem_we_o    = cpu_req_i && cpu_we_i;
        mem_addr_o  = cpu_req_i ? cpu_addr_i : scan_addr_i;
        mem_wdata_o = cpu_wdata_i;
    end
endmodule

// File: rtl/msgscan_walker.sv
module msgscan_walker
    import msgscan_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int OBJ_BYTES = 16,
    parameter int NUM_OBJ   = 32,
    parameter int OBJ_W     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ID_W-1:0]   rx_id_i,
    input  logic              frame_end_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_gnt_i,
    input  logic [7:0]        rd_data_i,
    output logic [7:0]        idx_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              overrun_o
);
    localparam logic [OBJ_W-1:0] LAST_OBJ = OBJ_W'(NUM_OBJ - 1);

    typedef struct packed {
        walk_state_e     st;
        logic [OBJ_W-1:0] obj;
        byte_sel_e       sel;
        logic            pend;
        logic [ID_W-1:0] rx_id;
        logic [7:0]      id_hi;
        logic [7:0]      idx;
        logic            done;
        logic            overrun;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [7:0] mode_byte;
    logic       obj_usable;
    logic       id_equal;

    always_comb begin
        mode_byte  = rd_data_i;
        obj_usable = mode_byte[MODE_EN] && !mode_byte[MODE_TX];
        id_equal   = ({q.id_hi, rd_data_i[7:5]} == q.rx_id);
    end

    always_comb begin
        rd_req_o  = (q.st == ST_WALK) && !q.pend;
        rd_addr_o = ADDR_W'(q.obj) * ADDR_W'(OBJ_BYTES) + ADDR_W'(q.sel);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_WALK;
                    d.obj   = '0;
                    d.sel   = SEL_MODE;
                    d.pend  = 1'b0;
                    d.rx_id = rx_id_i;
                end
            end
            ST_WALK: begin
                if (frame_end_i) begin
                    d.st      = ST_IDLE;
                    d.idx     = IDX_ERROR;
                    d.done    = 1'b1;
                    d.overrun = 1'b1;
                    d.pend    = 1'b0;
                end else if (!q.pend) begin
                    if (rd_gnt_i) begin
                        d.pend = 1'b1;
                    end
                end else begin
                    d.pend = 1'b0;
                    unique case (q.sel)
                        SEL_MODE: begin
                            if (mode_byte == END_MARK) begin
                                d.st   = ST_IDLE;
                                d.idx  = IDX_EMPTY;
                                d.done = 1'b1;
                            end else if (!obj_usable) begin
                                if (q.obj == LAST_OBJ) begin
                                    d.st   = ST_IDLE;
                                    d.idx  = IDX_EMPTY;
                                    d.done = 1'b1;
                                end else begin
                                    d.obj = q.obj + 1'b1;
                                    d.sel = SEL_MODE;
                                end
                            end else if (mode_byte[MODE_ALL]) begin
                                d.st   = ST_IDLE;
                                d.idx  = 8'(q.obj);
                                d.done = 1'b1;
                            end else begin
                                d.sel = SEL_ID_HI;
                            end
                        end
                        SEL_ID_HI: begin
                            d.id_hi = rd_data_i;
                            d.sel   = SEL_ID_LO;
                        end
                        SEL_ID_LO: begin
                            if (id_equal) begin
                                d.st   = ST_IDLE;
                                d.idx  = 8'(q.obj);
                                d.done = 1'b1;
                            end else if (q.obj == LAST_OBJ) begin
                                d.st   = ST_IDLE;
                                d.idx  = IDX_EMPTY;
                                d.done = 1'b1;
                            end else begin
                                d.obj = q.obj + 1'b1;
                                d.sel = SEL_MODE;
                            end
                        end
                        default: begin
                            d.sel = SEL_MODE;
                        end
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.obj     <= '0;
            q.sel     <= SEL_MODE;
            q.pend    <= 1'b0;
            q.rx_id   <= '0;
            q.id_hi   <= '0;
            q.idx     <= IDX_EMPTY;
            q.done    <= 1'b0;
            q.overrun <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign idx_o     = q.idx;
    assign done_o    = q.done;
    assign busy_o    = (q.st == ST_WALK);
    assign overrun_o = q.overrun;

    // A refused read must be retried at the same address.
    assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_gnt_i && !frame_end_i) |=> (rd_req_o && $stable(rd_addr_o)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (idx_o < 8'(NUM_OBJ) || idx_o >= IDX_ERROR));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    assert_deadline_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && frame_end_i) |=> (done_o && idx_o == IDX_ERROR && !busy_o));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !frame_end_i) |=> (busy_o || done_o));
endmodule

// File: rtl/msgscan_top.sv
module msgscan_top
    import msgscan_pkg::*;
#(
    parameter int RAM_BYTES = 512,
    parameter int OBJ_BYTES = 16,
    parameter int ADDR_W    = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [10:0]       rx_id_i,
    input  logic              frame_end_i,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [7:0]        cpu_wdata_i,
    output logic [7:0]        cpu_rdata_o,
    output logic [7:0]        idx_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              overrun_o
);
    localparam int SLOTS   = RAM_BYTES / OBJ_BYTES;
    localparam int NUM_OBJ = (SLOTS > MAX_OBJS) ? MAX_OBJS : SLOTS;

    logic              scan_req, scan_gnt;
    logic [ADDR_W-1:0] scan_addr;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    msgscan_arb #(.ADDR_W(ADDR_W)) i_arb (
        .cpu_req_i   (cpu_req_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .scan_req_i  (scan_req),
        .scan_addr_i (scan_addr),
        .scan_gnt_o  (scan_gnt),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata)
    );

    msgscan_ram #(.DEPTH(RAM_BYTES), .ADDR_W(ADDR_W)) i_ram (
        .clk     (clk),
        .en_i    (mem_en),
        .we_i    (mem_we),
        .addr_i  (mem_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    msgscan_walker #(
        .ADDR_W    (ADDR_W),
        .OBJ_BYTES (OBJ_BYTES),
        .NUM_OBJ   (NUM_OBJ)
    ) i_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rx_id_i     (rx_id_i),
        .frame_end_i (frame_end_i),
        .rd_req_o    (scan_req),
        .rd_addr_o   (scan_addr),
        .rd_gnt_i    (scan_gnt),
        .rd_data_i   (mem_rdata),
        .idx_o       (idx_o),
        .done_o      (done_o),
        .busy_o      (busy_o),
        .overrun_o   (overrun_o)
    );

    assign cpu_rdata_o = mem_rdata;
endmodule

// File: tb/test_msgscan_top.sv
module test_msgscan_top;
    localparam int CLK_PERIOD = 10;
    localparam int NOBJ = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] rx_id_i = '0;
    logic        frame_end_i = 1'b0;
    logic        cpu_req_i = 1'b0;
    logic        cpu_we_i = 1'b0;
    logic [8:0]  cpu_addr_i = '0;
    logic [7:0]  cpu_wdata_i = '0;
    logic [7:0]  cpu_rdata_o;
    logic [7:0]  idx_o;
    logic        done_o, busy_o, overrun_o;

    int checks = 0;
    int failures = 0;

    logic [7:0]  m_mode [NOBJ];
    logic [10:0] m_id   [NOBJ];

    always #(CLK_PERIOD/2) clk = ~clk;

    msgscan_top i_msgscan_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_id_i(rx_id_i),
        .frame_end_i(frame_end_i), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
        .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
        .idx_o(idx_o), .done_o(done_o), .busy_o(busy_o), .overrun_o(overrun_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input int addr, input logic [7:0] data);
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = 9'(addr); cpu_wdata_i = data;
        @(negedge clk);
        cpu_req_i = 1'b0; cpu_we_i = 1'b0;
    endtask

    task automatic cpu_read(input int addr, output logic [7:0] data);
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = 9'(addr);
        @(negedge clk);
        cpu_req_i = 1'b0;
        data = cpu_rdata_o;
    endtask

    task automatic set_obj(input int k, input logic [7:0] mode, input logic [10:0] id);
        cpu_write(k*16,     mode);
        cpu_write(k*16 + 1, id[10:3]);
        cpu_write(k*16 + 2, {id[2:0], 5'b0});
        m_mode[k] = mode;
        m_id[k]   = id;
    endtask

    // Reference lookup from the requirements: result and latency in cycles.
    task automatic model(input logic [10:0] id, output int idx, output int lat);
        lat = 0;
        idx = 255;
        for (int k = 0; k < NOBJ; k++) begin
            if (m_mode[k] == 8'hFF) begin
                lat += 2; idx = 255; return;
            end
            if (!m_mode[k][0] || m_mode[k][2]) begin
                lat += 2;
            end else if (m_mode[k][1]) begin
                lat += 2; idx = k; return;
            end else begin
                lat += 6;
                if (m_id[k] == id) begin idx = k; return; end
            end
        end
    endtask

    task automatic run_scan(input logic [10:0] id, input int stall, input int fe_at,
                            input int restart, output int idx, output int lat);
        int cnt;
        int busy_seen;
        busy_seen = 0;
        @(negedge clk);
        start_i = 1'b1; rx_id_i = id; cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) busy_seen = int'(busy_o);
            if (done_o) break;
            start_i     = (restart > 0 && cnt == restart);
            rx_id_i     = start_i ? ~id : id;
            cpu_req_i   = (cnt <= stall);
            cpu_we_i    = 1'b0;
            cpu_addr_i  = 9'd5;
            frame_end_i = (cnt == fe_at);
        end while (cnt < 3000);
        start_i = 1'b0; cpu_req_i = 1'b0; frame_end_i = 1'b0;
        lat = cnt - 1;
        idx = int'(idx_o);
        chk("R9 busy after start", busy_seen, 1);
        @(negedge clk);
        chk("R9 done single cycle", int'(done_o), 0);
        chk("R9 idle after done", int'(busy_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
        $finish;
    end

    initial begin
        int idx, lat, eidx, elat;
        logic [7:0] rb;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 idx reset", int'(idx_o), 255);
        chk("R10 done reset", int'(done_o), 0);
        chk("R10 busy reset", int'(busy_o), 0);
        chk("R10 overrun reset", int'(overrun_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: CPU write then read-back through the shared port
        cpu_write(300, 8'h5A);
        cpu_read(300, rb);
        chk("R6 cpu readback", int'(rb), 8'h5A);

        // R3/R5: all slots disabled, no terminator
        for (int k = 0; k < NOBJ; k++) set_obj(k, 8'h00, 11'(k));
        run_scan(11'd3, 0, 0, 0, idx, lat);
        chk("R5 disabled never match", idx, 255);
        chk("R7 skip cost", lat, 64);

        // R1/R3/R4/R7: distinct identifiers, sweep hit position plus a miss
        for (int k = 0; k < NOBJ; k++) set_obj(k, 8'h01, 11'(100 + k*37));
        for (int p = 0; p < NOBJ; p++) begin
            run_scan(11'(100 + p*37), 0, 0, 0, idx, lat);
            model(11'(100 + p*37), eidx, elat);
            chk("R1 R4 hit index", idx, eidx);
            chk("R7 hit latency", lat, elat);
        end
        run_scan(11'd2047, 0, 0, 0, idx, lat);
        chk("R3 miss full table", idx, 255);
        chk("R3 R7 full walk latency", lat, 6*NOBJ);

        // R4: duplicate identifier later in the table
        set_obj(20, 8'h01, 11'(100 + 7*37));
        run_scan(11'(100 + 7*37), 0, 0, 0, idx, lat);
        chk("R4 first match wins", idx, 7);
        set_obj(20, 8'h01, 11'(100 + 20*37));

        // R2: terminator in every slot with an accept-all slot after it
        for (int m = 0; m < NOBJ; m++) begin
            set_obj(m, 8'hFF, 11'd0);
            if (m + 1 < NOBJ) set_obj(m + 1, 8'h03, 11'd0);
            run_scan(11'd2047, 0, 0, 0, idx, lat);
            chk("R2 terminator stops scan", idx, 255);
            chk("R2 R7 terminator latency", lat, 6*m + 2);
            set_obj(m, 8'h01, 11'(100 + m*37));
            if (m + 1 < NOBJ) set_obj(m + 1, 8'h01, 11'(100 + (m+1)*37));
        end

        // R5: transmit and disabled objects holding the id, accept-all later
        set_obj(3, 8'h05, 11'd555);
        set_obj(4, 8'h00, 11'd555);
        set_obj(10, 8'h03, 11'd1);
        run_scan(11'd555, 0, 0, 0, idx, lat);
        model(11'd555, eidx, elat);
        chk("R5 accept-all after tx/disabled", idx, 10);
        chk("R5 R7 latency", lat, elat);

        // R6: CPU holds the port for 7 cycles at scan start
        model(11'(100 + 15*37), eidx, elat);
        run_scan(11'(100 + 15*37), 7, 0, 0, idx, lat);
        chk("R6 stall result", idx, eidx);
        chk("R6 stall latency", lat, elat + 7);

        // R9: start while busy is ignored
        run_scan(11'(100 + 20*37), 0, 0, 2, idx, lat);
        model(11'(100 + 20*37), eidx, elat);
        chk("R9 restart ignored idx", idx, eidx);
        chk("R9 restart ignored latency", lat, elat);

        // R8: frame_end while idle has no effect
        @(negedge clk); frame_end_i = 1'b1;
        @(negedge clk); frame_end_i = 1'b0;
        chk("R8 idle frame_end overrun", int'(overrun_o), 0);
        chk("R8 idle frame_end done", int'(done_o), 0);
        chk("R8 idle frame_end idx", int'(idx_o), eidx);

        // R8: deadline mid-scan
        run_scan(11'd2047, 0, 5, 0, idx, lat);
        chk("R8 deadline code", idx, 254);
        chk("R8 deadline latency", lat, 5);
        chk("R8 overrun set", int'(overrun_o), 1);
        run_scan(11'(100 + 2*37), 0, 0, 0, idx, lat);
        chk("R8 scan after overrun", idx, 2);
        chk("R8 overrun sticky", int'(overrun_o), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule